// File: doc/BRIEF.md
# SPI Receive Sample-Point Adjuster

This block moves the instant at which the serial receive line is captured, relative to the nominal receive edge of an SPI master. It corrects for board and pad delay. The receive line first passes through a delay line that holds it back by zero to three system-clock cycles. The block then captures the delayed value at an instant set by a signed capture code: two cycles early, one cycle early, on the nominal instant, or one cycle late.

The surrounding shift engine supplies a sample strobe that runs two cycles ahead of the nominal instant. Each capture offset is therefore a fixed delay of zero to three cycles from that early strobe, and no offset needs to look into the future. The block produces one captured bit and a one-cycle valid pulse for each strobe.

A word-tracking state machine loads both codes at the first strobe of a word. It holds them until the word's last capture has been made. Designs with faster bit rates select later capture codes.

Top module: `spi_sample_adjust`

States and transitions of the word tracker:
- `ST_IDLE`: no word is in flight, and the codes follow the inputs on every cycle. *start*: on a strobe, it moves to `ST_ACTIVE` (or to `ST_DRAIN` for one-bit words).
- `ST_ACTIVE`: it counts strobes. *last bit*: on the `WORD_BITS`-th strobe, it moves to `ST_DRAIN`.
- `ST_DRAIN`: it waits three cycles so that the last capture uses the word's codes. *drained*: it returns to `ST_IDLE`.

## Requirements
- R1: While reset is asserted and on the first cycle after it, `cap_valid_o` and `cap_bit_o` are 0.
- R2: Each strobe produces exactly one `cap_valid_o` pulse of one cycle, and no pulse appears without a strobe.
- R3: The capture code C (0 = two cycles early, 1 = one early, 2 = nominal, 3 = one late) places the pulse in the cycle that follows clock edge e+C+1, where e is the edge that samples the strobe. Nominal is edge e+2.
- R4: The input delay code D (0..3 = that many cycles) makes `cap_bit_o` equal the `miso_i` value sampled at edge e+C-D.
- R5: Code changes during a word have no effect on any capture of that word.
- R6: The codes applied to a word are the input values at the edge that samples the word's first strobe.
- R7: A word consists of exactly `WORD_BITS` strobes, and the next strobe after them starts a new word with newly loaded codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miso_i | input | 1 | Serial receive data |
| strobe_i | input | 1 | Early sample strobe, two cycles ahead of nominal |
| dly_code_i | input | 2 | Input delay code, 0..3 cycles |
| cap_code_i | input | 2 | Capture offset code, -2/-1/0/+1 cycles |
| cap_bit_o | output | 1 | Captured receive bit |
| cap_valid_o | output | 1 | One-cycle capture strobe |

## Verification
The assertions assume that strobes are at least four cycles apart, both inside a word and across a word boundary. With that spacing the strobe pipeline holds at most one strobe, and the drain ends before the next word loads its codes. The stimulus sweeps all sixteen code pairs. It alternates strobe spacings of four and five cycles, leaves at least four cycles between words, and drives scrambled codes part-way through every word.

// File: rtl/spi_adj_pkg.sv
package spi_adj_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_DRAIN  = 2'd2
    } word_state_t;
endpackage

// File: rtl/spi_adj_tapline.sv
// Shift line with a selectable tap: tap = input sampled sel edges before the last.
module spi_adj_tapline #(
    parameter int DEPTH = 4,
    localparam int SEL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             d,
    input  logic [SEL_W-1:0] sel,
    output logic             tap
);
    logic [DEPTH-1:0] line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line[0] <= 1'b0;
        else        line[0] <= d;
    end

    generate
        for (genvar i = 1; i < DEPTH; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) line[i] <= 1'b0;
                else        line[i] <= line[i-1];
            end
        end
    endgenerate

    assign tap = line[sel];
endmodule

// File: rtl/spi_adj_word_fsm.sv
// Tracks word boundaries and holds the codes steady for a whole word.
module spi_adj_word_fsm
    import spi_adj_pkg::*;
#(
    parameter int WORD_BITS = 8,
    parameter int CODE_W    = 2,
    localparam int CNT_W      = $clog2(WORD_BITS + 1),
    localparam int DRAIN_LAST = (1 << CODE_W) - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [CODE_W-1:0] dly_code_i,
    input  logic [CODE_W-1:0] cap_code_i,
    output logic [CODE_W-1:0] dly_sel,
    output logic [CODE_W-1:0] cap_sel,
    output logic              busy
);
    word_state_t state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CODE_W-1:0] drain_cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (strobe_i) state_nx = (WORD_BITS == 1) ? ST_DRAIN : ST_ACTIVE;
            ST_ACTIVE: if (strobe_i && bit_cnt == CNT_W'(WORD_BITS - 1)) state_nx = ST_DRAIN;
            ST_DRAIN:  if (drain_cnt == CODE_W'(DRAIN_LAST)) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            drain_cnt <= '0;
            dly_sel   <= '0;
            cap_sel   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    dly_sel   <= dly_code_i;
                    cap_sel   <= cap_code_i;
                    drain_cnt <= '0;
                    if (strobe_i) bit_cnt <= CNT_W'(1);
                end
                ST_ACTIVE: begin
                    drain_cnt <= '0;
                    if (strobe_i) bit_cnt <= bit_cnt + CNT_W'(1);
                end
                ST_DRAIN: drain_cnt <= drain_cnt + CODE_W'(1);
                default: ;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/spi_sample_adjust.sv
module spi_sample_adjust #(
    parameter int WORD_BITS = 8,
    parameter int CODE_W    = 2,
    localparam int DEPTH = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miso_i,
    input  logic              strobe_i,
    input  logic [CODE_W-1:0] dly_code_i,
    input  logic [CODE_W-1:0] cap_code_i,
    output logic              cap_bit_o,
    output logic              cap_valid_o
);
    logic [CODE_W-1:0] dly_sel, cap_sel;
    logic              word_busy, data_tap, strobe_tap;

    spi_adj_word_fsm #(.WORD_BITS(WORD_BITS), .CODE_W(CODE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i),
        .dly_code_i(dly_code_i), .cap_code_i(cap_code_i),
        .dly_sel(dly_sel), .cap_sel(cap_sel), .busy(word_busy)
    );

    // Receive delay line: tap picks the input delay.
    spi_adj_tapline #(.DEPTH(DEPTH)) u_data (
        .clk(clk), .rst_n(rst_n), .d(miso_i), .sel(dly_sel), .tap(data_tap)
    );

    // Early-strobe pipeline: tap picks the capture offset.
    spi_adj_tapline #(.DEPTH(DEPTH)) u_strobe (
        .clk(clk), .rst_n(rst_n), .d(strobe_i), .sel(cap_sel), .tap(strobe_tap)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_valid_o <= 1'b0;
            cap_bit_o   <= 1'b0;
        end else begin
            cap_valid_o <= strobe_tap;
            if (strobe_tap) cap_bit_o <= data_tap;
        end
    end
endmodule

// File: rtl/spi_sample_adjust_chk.sv
module spi_sample_adjust_chk #(
    parameter int CODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miso_i,
    input logic              strobe_i,
    input logic              cap_bit_o,
    input logic              cap_valid_o,
    input logic [CODE_W-1:0] cap_sel,
    input logic [CODE_W-1:0] dly_sel,
    input logic              word_busy
);
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid_o |=> !cap_valid_o);

    a_r2_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid_o |-> ($past(strobe_i, 2) || $past(strobe_i, 3)
                      || $past(strobe_i, 4) || $past(strobe_i, 5)));

    a_r3_two_early: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid_o && cap_sel == '0) |-> $past(strobe_i, 2));

    a_r4_no_delay_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid_o && cap_sel == '0 && dly_sel == '0) |-> cap_bit_o == $past(miso_i, 2));

    a_r5_codes_held: assert property (@(posedge clk) disable iff (!rst_n)
        (word_busy && $past(word_busy)) |-> ($stable(cap_sel) && $stable(dly_sel)));
endmodule

bind spi_sample_adjust spi_sample_adjust_chk #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .miso_i(miso_i), .strobe_i(strobe_i),
    .cap_bit_o(cap_bit_o), .cap_valid_o(cap_valid_o),
    .cap_sel(cap_sel), .dly_sel(dly_sel), .word_busy(word_busy)
);

// File: tb/spi_sample_adjust_test.sv
`timescale 1ns/1ps
module spi_sample_adjust_test;
    localparam int WB = 8;
    localparam int N  = 4096;

    logic clk = 1'b0, rst_n = 1'b0;
    logic miso_i = 1'b0, strobe_i = 1'b0;
    logic [1:0] dly_code_i = '0, cap_code_i = '0;
    logic cap_bit_o, cap_valid_o;

    spi_sample_adjust #(.WORD_BITS(WB)) uut (
        .clk(clk), .rst_n(rst_n), .miso_i(miso_i), .strobe_i(strobe_i),
        .dly_code_i(dly_code_i), .cap_code_i(cap_code_i),
        .cap_bit_o(cap_bit_o), .cap_valid_o(cap_valid_o)
    );

    always #2.5 clk = ~clk;

    int ecount = 0;
    always @(posedge clk) ecount <= ecount + 1;

    int checks = 0, fails = 0;
    bit done = 0;
    logic mh [N];
    logic sb [N];
    int   sdly [N], scap [N];
    string stag [N];
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at edge %0d: actual %0d expected %0d", req, ecount, act, exp);
        end
    endtask

    task automatic verify();
        int n, k, src;
        bit ev;
        string tg;
        n = ecount; ev = 0; src = -1; tg = "R3";
        for (int c = 0; c < 4; c++) begin
            k = n - 1 - c;
            if (k >= 0 && sb[k] && scap[k] == c) begin
                ev = 1; src = n - 1 - sdly[k]; tg = stag[k];
            end
        end
        check(cap_valid_o == ev, ev ? {"R3 ", tg} : "R2", cap_valid_o, ev);
        if (ev && src >= 0)
            check(cap_bit_o == mh[src], {"R4 ", tg}, cap_bit_o, mh[src]);
    endtask

    task automatic step(input logic s, input logic [1:0] d, input logic [1:0] c,
                        input int wd, input int wc, input string tg);
        int n;
        @(negedge clk);
        verify();
        n = ecount + 1;
        miso_i = lfsr[0];
        mh[n] = lfsr[0];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        strobe_i = s; dly_code_i = d; cap_code_i = c;
        sb[n] = s; sdly[n] = wd; scap[n] = wc; stag[n] = tg;
    endtask

    initial begin
        #500000;
        fails++; checks++;
        $display("FAIL watchdog expired, actual 0 expected 1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            mh[i] = 0; sb[i] = 0; sdly[i] = 0; scap[i] = 0; stag[i] = "";
        end
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check(cap_valid_o == 0 && cap_bit_o == 0, "R1", {cap_valid_o, cap_bit_o}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(cap_valid_o == 0 && cap_bit_o == 0, "R1", {cap_valid_o, cap_bit_o}, 0);
        for (int w = 0; w < 16; w++) begin
            int wd, wc;
            wd = w % 4; wc = w / 4;
            for (int s = 0; s < WB; s++) begin
                logic [1:0] dd, cc;
                string tg;
                // R5: scrambled codes from the third strobe on
                dd = (s >= 2) ? ~2'(wd) : 2'(wd);
                cc = (s >= 2) ? 2'(wc) ^ 2'd2 : 2'(wc);
                tg = (s == 0) ? "R6" : (s == WB - 1) ? "R7" : (s >= 2) ? "R5" : "R4";
                step(1'b1, dd, cc, wd, wc, tg);
                for (int g = 0; g < 3 + (s % 2); g++) step(1'b0, dd, cc, wd, wc, "");
            end
            // gap before the next word: codes of the next pair driven
            for (int g = 0; g < 4; g++)
                step(1'b0, 2'((w + 1) % 4), 2'(((w + 1) / 4) % 4), 0, 0, "");
        end
        for (int g = 0; g < 6; g++) step(1'b0, 2'd0, 2'd0, 0, 0, "");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule